// File: doc/BRIEF.md
# Banked Data Memory Address Mapper

This block turns an 8-bit processor's file accesses into locations in a banked data space. The space has 32 banks of 128 bytes. A direct access gives a 7-bit in-bank offset. The block joins that offset to the 5-bit bank number held in its own bank register, which gives a 12-bit bank/offset pair. An indirect access goes through one of two 16-bit pointers. The pointer's bits [11:7] give the bank, bits [6:0] give the offset, and bits [15:12] must be zero.

Each offset falls into one of four regions:

| Region | Offsets | Code on `rsp_region` |
|---|---|---|
| core | 0x00–0x0B | 0 |
| special function | 0x0C–0x1F | 1 |
| general purpose RAM | 0x20–0x6F | 2 |
| common RAM | 0x70–0x7F | 3 |

The core offsets and the 16-byte common RAM reach the same storage from every bank. General purpose RAM is held only for the first `GPR_BANKS` banks. Special function locations return zero here, and the bank, region and physical index are passed out so that a neighbour can decode them.

Every access goes through a three-state sequencer:

- `S_IDLE` accepts a request.
- `S_PTR` resolves a pointer. Only indirect accesses pass through it.
- `S_ACCESS` presents the response for one cycle and commits any write.

The transitions are:

- `S_IDLE→S_ACCESS` for a direct request.
- `S_IDLE→S_PTR` for an indirect request.
- `S_PTR→S_ACCESS`.
- `S_ACCESS→S_IDLE`.

Top module: `bankmap_top`

## Requirements
- R1: After reset, `busy` and `rsp_valid` are 0, and the bank register and both pointers read back as zero.
- R2: `rsp_region` reports the region of the effective offset: 0 for core (0x00–0x0B), 1 for special function (0x0C–0x1F), 2 for general purpose RAM (0x20–0x6F), 3 for common RAM (0x70–0x7F).
- R3: A write to core offset 0x08 stores bits [4:0] as the bank number. Reading 0x08 returns that number zero-extended. Direct accesses use that bank, and `rsp_bank` reports it.
- R4: General purpose RAM at bank b < `GPR_BANKS` and offset o has `rsp_phys` = b*80 + (o − 0x20). Each bank has its own storage, and a write followed by a read returns the written byte.
- R5: Offsets 0x70–0x7F reach one shared 16-byte store from every bank, with `rsp_phys` = o − 0x70.
- R6: Core offsets reach the same registers whichever bank is selected.
- R7: Reads from unimplemented locations return zero, and writes to them change nothing. Unimplemented locations are: special function offsets; core offsets 0x02, 0x03 and 0x09–0x0B; general purpose RAM in banks ≥ `GPR_BANKS`, where `rsp_phys` is also 0; and pointer values with bits [15:12] non-zero.
- R8: Pointer 0 is written as a low byte at 0x04 and a high byte at 0x05. Pointer 1 is written the same way at 0x06 and 0x07. Each byte changes independently.
- R9: An access at offset 0x00 uses pointer 0 and an access at 0x01 uses pointer 1. `rsp_bank`, `rsp_region` and `rsp_phys` then describe the target. A pointer whose target is offset 0x00 or 0x01 reads zero and ignores writes.
- R10: `rsp_valid` pulses for one cycle. It comes 1 cycle after the accepting edge for a direct access and 2 cycles after for an indirect one. `busy` is high while not in `S_IDLE`. Requests made while busy are ignored. `rsp_rdata` is zero on a write response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request, taken in `S_IDLE` |
| req_we | input | 1 | 1 = write, 0 = read |
| req_offs | input | 7 | Direct in-bank offset |
| req_wdata | input | 8 | Write data |
| busy | output | 1 | Sequencer not idle |
| rsp_valid | output | 1 | Response cycle |
| rsp_region | output | 2 | Region code of the effective location |
| rsp_bank | output | 5 | Effective bank number |
| rsp_phys | output | PHYS_W | Physical index within the region |
| rsp_rdata | output | 8 | Read data, zero for unimplemented locations |

## Verification
The main function is tried with several patterns:

- The same offsets under different bank numbers. These separate per-bank general purpose storage from the shared common and core storage.
- Offsets at each region edge, which separate the four region codes.
- A bank number above the implemented range and an all-ones bank write. These separate stored bits from zero-filled ones.
- Indirect accesses through each pointer. These show that the pointer, and not the bank register, chooses the target.
- Out-of-range pointers and a pointer aimed at an indirect data offset.
- A request placed while busy, which must leave storage untouched.

// File: rtl/bankmap_pkg.sv
package bankmap_pkg;
    localparam int OFFS_W       = 7;
    localparam int BANK_W       = 5;
    localparam int DATA_W       = 8;
    localparam int PTR_W        = 2 * DATA_W;
    localparam int N_PTR        = 2;
    localparam int GPR_BYTES    = 80;
    localparam int COMMON_BYTES = 16;
    localparam int COM_AW       = $clog2(COMMON_BYTES);

    // region boundaries inside a bank
    localparam logic [OFFS_W-1:0] CORE_LIM = 7'h0C;
    localparam logic [OFFS_W-1:0] SFR_LIM  = 7'h20;
    localparam logic [OFFS_W-1:0] GPR_LIM  = 7'h70;

    // core register offsets owned by this block
    localparam logic [OFFS_W-1:0] OFF_IND0    = 7'h00;
    localparam logic [OFFS_W-1:0] OFF_IND1    = 7'h01;
    localparam logic [OFFS_W-1:0] OFF_P0L     = 7'h04;
    localparam logic [OFFS_W-1:0] OFF_BANKSEL = 7'h08;

    typedef enum logic [1:0] {
        RGN_CORE   = 2'd0,
        RGN_SFR    = 2'd1,
        RGN_GPR    = 2'd2,
        RGN_COMMON = 2'd3
    } region_e;

    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_PTR    = 2'd1,
        S_ACCESS = 2'd2
    } state_e;
endpackage

// File: rtl/bankmap_decode.sv
module bankmap_decode
    import bankmap_pkg::*;
#(
    parameter int GPR_BANKS = 4,
    parameter int PHYS_W    = 9
) (
    input  logic [BANK_W-1:0] bank,
    input  logic [OFFS_W-1:0] offs,
    output region_e           rgn,
    output logic              gpr_hit,
    output logic [PHYS_W-1:0] phys
);
    always_comb begin
        int lin;
        lin     = 0;
        gpr_hit = 1'b0;
        phys    = '0;
        if (offs < CORE_LIM) begin
            rgn  = RGN_CORE;
            phys = PHYS_W'(offs);
        end else if (offs < SFR_LIM) begin
            rgn  = RGN_SFR;
            phys = PHYS_W'(offs);
        end else if (offs < GPR_LIM) begin
            rgn = RGN_GPR;
            if (int'(bank) < GPR_BANKS) begin
                gpr_hit = 1'b1;
                lin     = int'(bank) * GPR_BYTES + int'(offs) - int'(SFR_LIM);
                phys    = PHYS_W'(lin);
            end
        end else begin
            rgn  = RGN_COMMON;
            phys = PHYS_W'(offs - GPR_LIM);
        end
    end
endmodule

// File: rtl/bankmap_regs.sv
module bankmap_regs
    import bankmap_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [OFFS_W-1:0]           offs,
    input  logic [DATA_W-1:0]           wr_data,
    output logic [BANK_W-1:0]           bsr,
    output logic [N_PTR-1:0][PTR_W-1:0] ptr,
    output logic [DATA_W-1:0]           rd_data
);
    logic [BANK_W-1:0] bsr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                            bsr_q <= '0;
        else if (wr_en && offs == OFF_BANKSEL) bsr_q <= wr_data[BANK_W-1:0];
    end
    assign bsr = bsr_q;

    for (genvar g = 0; g < N_PTR; g++) begin : g_ptr
        localparam logic [OFFS_W-1:0] LO_OFF = OFF_P0L + OFFS_W'(2 * g);
        localparam logic [OFFS_W-1:0] HI_OFF = LO_OFF + OFFS_W'(1);
        logic [DATA_W-1:0] lo_q, hi_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                lo_q <= '0;
                hi_q <= '0;
            end else if (wr_en) begin
                if (offs == LO_OFF) lo_q <= wr_data;
                if (offs == HI_OFF) hi_q <= wr_data;
            end
        end
        assign ptr[g] = {hi_q, lo_q};
    end

    always_comb begin
        rd_data = '0;
        if (offs == OFF_BANKSEL) rd_data = DATA_W'(bsr_q);
        for (int i = 0; i < N_PTR; i++) begin
            if (offs == OFF_P0L + OFFS_W'(2 * i))     rd_data = ptr[i][DATA_W-1:0];
            if (offs == OFF_P0L + OFFS_W'(2 * i + 1)) rd_data = ptr[i][PTR_W-1:DATA_W];
        end
    end
endmodule

// File: rtl/bankmap_store.sv
module bankmap_store
    import bankmap_pkg::*;
#(
    parameter int GPR_DEPTH = 320,
    parameter int PHYS_W    = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              gpr_we,
    input  logic [PHYS_W-1:0] gpr_addr,
    input  logic              com_we,
    input  logic [COM_AW-1:0] com_addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] gpr_rdata,
    output logic [DATA_W-1:0] com_rdata
);
    logic [DATA_W-1:0] gpr_mem [GPR_DEPTH];
    logic [DATA_W-1:0] com_mem [COMMON_BYTES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < GPR_DEPTH; i++) gpr_mem[i] <= '0;
        end else if (gpr_we && int'(gpr_addr) < GPR_DEPTH) begin
            gpr_mem[gpr_addr] <= wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < COMMON_BYTES; i++) com_mem[i] <= '0;
        end else if (com_we) begin
            com_mem[com_addr] <= wdata;
        end
    end

    assign gpr_rdata = (int'(gpr_addr) < GPR_DEPTH) ? gpr_mem[gpr_addr] : '0;
    assign com_rdata = com_mem[com_addr];
endmodule

// File: rtl/bankmap_top.sv
module bankmap_top
    import bankmap_pkg::*;
#(
    parameter  int GPR_BANKS = 4,
    localparam int GPR_DEPTH = GPR_BANKS * GPR_BYTES,
    localparam int PHYS_W    = ($clog2(GPR_DEPTH) > OFFS_W) ? $clog2(GPR_DEPTH) : OFFS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_we,
    input  logic [OFFS_W-1:0] req_offs,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              busy,
    output logic              rsp_valid,
    output logic [1:0]        rsp_region,
    output logic [BANK_W-1:0] rsp_bank,
    output logic [PHYS_W-1:0] rsp_phys,
    output logic [DATA_W-1:0] rsp_rdata
);
    state_e state_q, state_d;

    logic              we_q, sel_q, bad_q;
    logic [DATA_W-1:0] wdata_q;
    logic [BANK_W-1:0] bank_q;
    logic [OFFS_W-1:0] eoffs_q;

    logic [BANK_W-1:0]           bsr;
    logic [N_PTR-1:0][PTR_W-1:0] ptr;
    logic [PTR_W-1:0]            tgt;
    logic [DATA_W-1:0]           core_rdata, gpr_rdata, com_rdata, rd_sel;
    region_e                     rgn;
    logic                        gpr_hit, req_ind;
    logic [PHYS_W-1:0]           phys;
    logic                        core_we, gpr_we, com_we;

    assign req_ind = (req_offs == OFF_IND0) || (req_offs == OFF_IND1);
    assign tgt     = ptr[sel_q];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (req_valid) state_d = req_ind ? S_PTR : S_ACCESS;
            S_PTR:    state_d = S_ACCESS;
            S_ACCESS: state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    // request capture and pointer resolution
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            we_q    <= 1'b0;
            sel_q   <= 1'b0;
            bad_q   <= 1'b0;
            wdata_q <= '0;
            bank_q  <= '0;
            eoffs_q <= '0;
        end else if (state_q == S_IDLE && req_valid) begin
            we_q    <= req_we;
            wdata_q <= req_wdata;
            sel_q   <= req_offs[0];
            bank_q  <= bsr;
            eoffs_q <= req_offs;
            bad_q   <= 1'b0;
        end else if (state_q == S_PTR) begin
            bank_q  <= tgt[OFFS_W+BANK_W-1:OFFS_W];
            eoffs_q <= tgt[OFFS_W-1:0];
            bad_q   <= (|tgt[PTR_W-1:OFFS_W+BANK_W])
                       || tgt[OFFS_W-1:0] == OFF_IND0
                       || tgt[OFFS_W-1:0] == OFF_IND1;
        end
    end

    bankmap_decode #(.GPR_BANKS(GPR_BANKS), .PHYS_W(PHYS_W)) u_decode (
        .bank    (bank_q),
        .offs    (eoffs_q),
        .rgn     (rgn),
        .gpr_hit (gpr_hit),
        .phys    (phys)
    );

    bankmap_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (core_we),
        .offs    (eoffs_q),
        .wr_data (wdata_q),
        .bsr     (bsr),
        .ptr     (ptr),
        .rd_data (core_rdata)
    );

    bankmap_store #(.GPR_DEPTH(GPR_DEPTH), .PHYS_W(PHYS_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .gpr_we    (gpr_we),
        .gpr_addr  (phys),
        .com_we    (com_we),
        .com_addr  (phys[COM_AW-1:0]),
        .wdata     (wdata_q),
        .gpr_rdata (gpr_rdata),
        .com_rdata (com_rdata)
    );

    // outputs and write strobes
    always_comb begin
        busy      = (state_q != S_IDLE);
        rsp_valid = (state_q == S_ACCESS);
        core_we   = 1'b0;
        gpr_we    = 1'b0;
        com_we    = 1'b0;
        rd_sel    = '0;
        unique case (rgn)
            RGN_CORE: begin
                rd_sel  = core_rdata;
                core_we = rsp_valid && we_q && !bad_q;
            end
            RGN_GPR: begin
                rd_sel = gpr_hit ? gpr_rdata : '0;
                gpr_we = rsp_valid && we_q && !bad_q && gpr_hit;
            end
            RGN_COMMON: begin
                rd_sel = com_rdata;
                com_we = rsp_valid && we_q && !bad_q;
            end
            default: rd_sel = '0;
        endcase
        if (bad_q) rd_sel = '0;
        rsp_region = rgn;
        rsp_bank   = bank_q;
        rsp_phys   = phys;
        rsp_rdata  = (rsp_valid && !we_q) ? rd_sel : '0;
    end
endmodule

// File: rtl/bankmap_sva.sv
module bankmap_sva
    import bankmap_pkg::*;
#(
    parameter int GPR_BANKS = 4,
    parameter int PHYS_W    = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              busy,
    input logic              rsp_valid,
    input logic [1:0]        rsp_region,
    input logic [BANK_W-1:0] rsp_bank,
    input logic [PHYS_W-1:0] rsp_phys,
    input logic [DATA_W-1:0] rsp_rdata
);
    // R10: response lasts one cycle
    a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R10: a response only appears while busy
    a_r10_valid_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> busy);

    // R10: an accepted request makes the block busy
    a_r10_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy) |=> busy);

    // R5: common index stays inside the shared store
    a_r5_common_index: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_region == RGN_COMMON) |-> int'(rsp_phys) < COMMON_BYTES);

    // R7: special function locations read zero here
    a_r7_sfr_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_region == RGN_SFR) |-> rsp_rdata == '0);

    // R7: general purpose RAM beyond the held banks reads zero
    a_r7_far_bank_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_region == RGN_GPR && int'(rsp_bank) >= GPR_BANKS)
        |-> (rsp_rdata == '0 && rsp_phys == '0));

    // R4: held general purpose RAM index is inside the array
    a_r4_gpr_index: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_region == RGN_GPR && int'(rsp_bank) < GPR_BANKS)
        |-> int'(rsp_phys) < GPR_BANKS * GPR_BYTES);
endmodule

bind bankmap_top bankmap_sva #(.GPR_BANKS(GPR_BANKS), .PHYS_W(PHYS_W)) u_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .busy       (busy),
    .rsp_valid  (rsp_valid),
    .rsp_region (rsp_region),
    .rsp_bank   (rsp_bank),
    .rsp_phys   (rsp_phys),
    .rsp_rdata  (rsp_rdata)
);

// File: tb/bankmap_top_bench.sv
`timescale 1ns/1ps
module bankmap_top_bench;
    localparam int PHYS_W = 9;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_we = 1'b0;
    logic [6:0]        req_offs = '0;
    logic [7:0]        req_wdata = '0;
    logic              busy, rsp_valid;
    logic [1:0]        rsp_region;
    logic [4:0]        rsp_bank;
    logic [PHYS_W-1:0] rsp_phys;
    logic [7:0]        rsp_rdata;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    bankmap_top u_bankmap_top (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_we(req_we),
        .req_offs(req_offs), .req_wdata(req_wdata), .busy(busy),
        .rsp_valid(rsp_valid), .rsp_region(rsp_region), .rsp_bank(rsp_bank),
        .rsp_phys(rsp_phys), .rsp_rdata(rsp_rdata)
    );

    typedef struct packed {
        logic        we;
        logic [6:0]  offs;
        logic [7:0]  wdata;
        logic [7:0]  exp_rd;
        logic [1:0]  exp_rgn;
        logic [4:0]  exp_bank;
        logic [8:0]  exp_phys;
    } vec_t;

    localparam int NV = 34;
    // region codes: 0 core, 1 sfr, 2 gpr, 3 common (R2)
    localparam vec_t VECS [NV] = '{
        '{1'b1, 7'h08, 8'h02, 8'h00, 2'd0, 5'd0,  9'd8},   // R3 select bank 2
        '{1'b1, 7'h20, 8'hA5, 8'h00, 2'd2, 5'd2,  9'd160}, // R4
        '{1'b1, 7'h70, 8'h3C, 8'h00, 2'd3, 5'd2,  9'd0},   // R5
        '{1'b0, 7'h08, 8'h00, 8'h02, 2'd0, 5'd2,  9'd8},   // R3
        '{1'b1, 7'h08, 8'h01, 8'h00, 2'd0, 5'd2,  9'd8},
        '{1'b0, 7'h20, 8'h00, 8'h00, 2'd2, 5'd1,  9'd80},  // R4 own bank
        '{1'b0, 7'h70, 8'h00, 8'h3C, 2'd3, 5'd1,  9'd0},   // R5 shared
        '{1'b1, 7'h45, 8'hC3, 8'h00, 2'd2, 5'd1,  9'd117},
        '{1'b1, 7'h08, 8'h02, 8'h00, 2'd0, 5'd1,  9'd8},
        '{1'b0, 7'h20, 8'h00, 8'hA5, 2'd2, 5'd2,  9'd160}, // R4
        '{1'b0, 7'h45, 8'h00, 8'h00, 2'd2, 5'd2,  9'd197}, // R4 distinct
        '{1'b1, 7'h08, 8'hFF, 8'h00, 2'd0, 5'd2,  9'd8},
        '{1'b0, 7'h08, 8'h00, 8'h1F, 2'd0, 5'd31, 9'd8},   // R3 five bits
        '{1'b0, 7'h20, 8'h00, 8'h00, 2'd2, 5'd31, 9'd0},   // R7
        '{1'b1, 7'h6F, 8'h77, 8'h00, 2'd2, 5'd31, 9'd0},
        '{1'b0, 7'h6F, 8'h00, 8'h00, 2'd2, 5'd31, 9'd0},   // R7
        '{1'b1, 7'h0C, 8'h99, 8'h00, 2'd1, 5'd31, 9'd12},
        '{1'b0, 7'h0C, 8'h00, 8'h00, 2'd1, 5'd31, 9'd12},  // R7 sfr
        '{1'b0, 7'h03, 8'h00, 8'h00, 2'd0, 5'd31, 9'd3},   // R7 core gap
        '{1'b1, 7'h7F, 8'h11, 8'h00, 2'd3, 5'd31, 9'd15},
        '{1'b1, 7'h04, 8'h34, 8'h00, 2'd0, 5'd31, 9'd4},   // R8
        '{1'b1, 7'h05, 8'h01, 8'h00, 2'd0, 5'd31, 9'd5},   // R8
        '{1'b1, 7'h08, 8'h00, 8'h00, 2'd0, 5'd31, 9'd8},
        '{1'b0, 7'h7F, 8'h00, 8'h11, 2'd3, 5'd0,  9'd15},  // R5
        '{1'b0, 7'h04, 8'h00, 8'h34, 2'd0, 5'd0,  9'd4},   // R6
        '{1'b0, 7'h05, 8'h00, 8'h01, 2'd0, 5'd0,  9'd5},   // R6
        '{1'b1, 7'h00, 8'h5A, 8'h00, 2'd2, 5'd2,  9'd180}, // R9 ptr0
        '{1'b0, 7'h00, 8'h00, 8'h5A, 2'd2, 5'd2,  9'd180}, // R9
        '{1'b1, 7'h08, 8'h02, 8'h00, 2'd0, 5'd0,  9'd8},
        '{1'b0, 7'h34, 8'h00, 8'h5A, 2'd2, 5'd2,  9'd180}, // R9 landed
        '{1'b1, 7'h06, 8'h7A, 8'h00, 2'd0, 5'd2,  9'd6},   // R8
        '{1'b0, 7'h01, 8'h00, 8'h00, 2'd3, 5'd0,  9'd10},  // R9 ptr1
        '{1'b1, 7'h01, 8'hE7, 8'h00, 2'd3, 5'd0,  9'd10},
        '{1'b0, 7'h7A, 8'h00, 8'hE7, 2'd3, 5'd2,  9'd10}   // R5 R9
    };

    task automatic check(input bit ok, input string tag, input logic [31:0] got,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // drives at a falling edge, returns at a falling edge with the block idle
    task automatic access(input logic we, input logic [6:0] offs, input logic [7:0] wd,
                          output logic [7:0] rd, output logic [1:0] rg,
                          output logic [4:0] bk, output logic [PHYS_W-1:0] ph,
                          output int lat);
        req_valid = 1'b1; req_we = we; req_offs = offs; req_wdata = wd;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        while (!rsp_valid && lat < 6) begin
            @(negedge clk);
            lat++;
        end
        rd = rsp_rdata; rg = rsp_region; bk = rsp_bank; ph = rsp_phys;
        @(negedge clk);
    endtask

    task automatic rd_expect(input logic [6:0] offs, input logic [7:0] exp, input string tag);
        logic [7:0] rd; logic [1:0] rg; logic [4:0] bk; logic [PHYS_W-1:0] ph; int lat;
        access(1'b0, offs, 8'h00, rd, rg, bk, ph, lat);
        check(rd == exp, tag, 32'(rd), 32'(exp));
    endtask

    task automatic wr(input logic [6:0] offs, input logic [7:0] d);
        logic [7:0] rd; logic [1:0] rg; logic [4:0] bk; logic [PHYS_W-1:0] ph; int lat;
        access(1'b1, offs, d, rd, rg, bk, ph, lat);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] rd; logic [1:0] rg; logic [4:0] bk; logic [PHYS_W-1:0] ph; int lat;
        repeat (3) @(negedge clk);
        check(busy == 1'b0, "R1 busy in reset", 32'(busy), 0);
        check(rsp_valid == 1'b0, "R1 rsp_valid in reset", 32'(rsp_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        rd_expect(7'h08, 8'h00, "R1 bank register");
        rd_expect(7'h04, 8'h00, "R1 ptr0 low");
        rd_expect(7'h05, 8'h00, "R1 ptr0 high");
        rd_expect(7'h06, 8'h00, "R1 ptr1 low");
        rd_expect(7'h07, 8'h00, "R1 ptr1 high");

        // vector walk: R2 R3 R4 R5 R6 R7 R8 R9
        for (int i = 0; i < NV; i++) begin
            access(VECS[i].we, VECS[i].offs, VECS[i].wdata, rd, rg, bk, ph, lat);
            check({rd, rg, bk, ph} == {VECS[i].exp_rd, VECS[i].exp_rgn,
                                       VECS[i].exp_bank, VECS[i].exp_phys},
                  $sformatf("R2 R3 R4 R5 R9 vector %0d {rd,rgn,bank,phys}", i),
                  32'({rd, rg, bk, ph}),
                  32'({VECS[i].exp_rd, VECS[i].exp_rgn, VECS[i].exp_bank, VECS[i].exp_phys}));
        end

        // R10 latency: direct 1, indirect 2
        access(1'b0, 7'h34, 8'h00, rd, rg, bk, ph, lat);
        check(lat == 1 && rd == 8'h5A, "R10 direct latency", 32'(lat), 1);
        access(1'b0, 7'h00, 8'h00, rd, rg, bk, ph, lat);
        check(lat == 2 && rd == 8'h5A, "R10 indirect latency", 32'(lat), 2);

        // R10 request while busy is ignored
        req_valid = 1'b1; req_we = 1'b0; req_offs = 7'h01; req_wdata = 8'h00;
        @(posedge clk);
        @(negedge clk);
        check(busy == 1'b1 && rsp_valid == 1'b0, "R10 busy during pointer step",
              32'({busy, rsp_valid}), 32'b10);
        req_we = 1'b1; req_offs = 7'h72; req_wdata = 8'h66;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        check(rsp_valid == 1'b1 && rsp_rdata == 8'hE7, "R10 indirect response",
              32'({rsp_valid, rsp_rdata}), 32'h1E7);
        @(negedge clk);
        check(busy == 1'b0 && rsp_valid == 1'b0, "R10 single pulse", 32'({busy, rsp_valid}), 0);
        rd_expect(7'h72, 8'h00, "R10 busy request ignored");

        // R7 pointer with high bits set
        wr(7'h07, 8'h10);
        rd_expect(7'h01, 8'h00, "R7 out-of-range pointer read");
        wr(7'h01, 8'h44);
        rd_expect(7'h7A, 8'hE7, "R7 out-of-range pointer write ignored");

        // R9 pointer aimed at an indirect data offset
        wr(7'h04, 8'h00);
        wr(7'h05, 8'h00);
        rd_expect(7'h00, 8'h00, "R9 self-referencing pointer");

        // R8 high byte alone leaves low byte
        wr(7'h05, 8'h01);
        rd_expect(7'h04, 8'h00, "R8 low byte kept");
        rd_expect(7'h05, 8'h01, "R8 high byte written");

        finish_run();
    end
endmodule